// File: doc/BRIEF.md
# Banked Serial-Port Register File

This block is the byte-wide register file of a 16550-style serial controller. A host reaches it over a simple synchronous bus that carries a 3-bit register index, a select, a write flag and 8-bit data. The block holds the framing configuration, the modem-line outputs, the interrupt enables and the 16-bit baud divisor. It drives these values to the neighbouring serializer, FIFOs, baud generator and interrupt logic.

Offsets 0 and 1 are banked under a divisor-access bit in line control. When that bit is clear, offset 0 carries transmit and receive data and offset 1 holds the interrupt enables. When it is set, both offsets hold divisor bytes. Offset 2 has a different meaning on read and on write. Data moves through combinational one-cycle strobes toward the datapath. The line status byte is built from live status inputs and from error flags latched from event pulses.

Top module: `uart_regbank`

## Requirements
- R1: Reset (rst_n low) clears line control, modem control, interrupt enables and the divisor. A line status read in the first cycle after reset returns 0x60.
- R2: With the divisor-access bit clear, a write to offset 0 raises tx_push for that cycle and tx_byte carries the write data. A read of offset 0 in the same state returns rx_byte and raises rx_pop for that cycle.
- R3: With the divisor-access bit set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. Neither offset raises a strobe in this state.
- R4: With the divisor-access bit clear, offset 1 holds the interrupt enables in bits 3:0 and reads 0 in bits 7:4. Bit 0 is receive data, bit 1 transmit empty, bit 2 line status and bit 3 modem status.
- R5: A read of offset 2 returns int_id. A write to offset 2 raises fifo_ctl_wr for that cycle, with fifo_ctl carrying the data, and changes no register.
- R6: Offset 3 is line control. Bits 1:0 set the word length (codes 0 to 3 mean 5 to 8 bits), bit 2 selects two stop bits, bit 3 enables parity, bit 4 selects even parity, bit 5 selects stick parity, bit 6 forces a break and bit 7 is the divisor-access bit.
- R7: Offset 4 is modem control. Bit 0 drives dtr, bit 1 rts, bit 2 out1, bit 3 out2, bit 4 loopback and bit 5 auto_flow. Bits 7:6 read 0.
- R8: Offset 5 reads line status. Bit 0 is data ready, bit 5 holding register empty and bit 6 transmitter empty, each taken from its status input one clock earlier. Bits 1 to 4 are the latched overrun, parity, framing and break flags. Bit 7 reads 0.
- R9: Each event pulse sets its line status flag, and the flag stays set until a line status read. That read clears the flags at the end of its cycle, except that an event arriving in the same cycle leaves its flag set.
- R10: Offset 6 returns modem_stat and offset 7 reads 0. Writes to offsets 5, 6 and 7 change no register.
- R11: Strobes appear only in a cycle with bus_sel high, and at most one of tx_push, rx_pop and fifo_ctl_wr is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_byte | input | 8 | Head of receive path |
| rx_pop | output | 1 | Receive pop strobe |
| tx_push | output | 1 | Transmit push strobe |
| tx_byte | output | 8 | Byte to push |
| fifo_ctl_wr | output | 1 | FIFO control write strobe |
| fifo_ctl | output | 8 | FIFO control byte |
| int_id | input | 8 | Interrupt identification byte |
| modem_stat | input | 8 | Modem status byte |
| st_rx_ready | input | 1 | Receive data available |
| st_tx_hold_empty | input | 1 | Transmit holding space empty |
| st_tx_idle | input | 1 | Transmitter fully idle |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_break | input | 1 | Break event pulse |
| word_len | output | 2 | Word length code |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity enable |
| even_parity | output | 1 | Even parity select |
| stick_parity | output | 1 | Stick parity select |
| send_break | output | 1 | Force break on line |
| div_access | output | 1 | Divisor-access bit |
| dtr | output | 1 | DTR line |
| rts | output | 1 | RTS line |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2 |
| loopback | output | 1 | Loopback mode |
| auto_flow | output | 1 | Auto flow control enable |
| int_en | output | 4 | Interrupt enables |
| divisor | output | 16 | Baud divisor |

## Verification
The assertions assume that bus_addr, bus_wr and bus_wdata are meaningful only when bus_sel is high, and that event pulses may arrive in any cycle, including the cycle of a status read. They make no assumption about int_id, modem_stat or rx_byte. The stimulus changes every input only on the falling clock edge. It issues one access per cycle with random offsets, directions and data, and it raises random event pulses on about a quarter of the cycles. Directed steps cover reset, both banks of offsets 0 and 1, and an event that coincides with a status read.

// File: rtl/uart_regbank.sv
module uart_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  rx_byte,
  output logic        rx_pop,
  output logic        tx_push,
  output logic [7:0]  tx_byte,
  output logic        fifo_ctl_wr,
  output logic [7:0]  fifo_ctl,
  input  logic [7:0]  int_id,
  input  logic [7:0]  modem_stat,
  input  logic        st_rx_ready,
  input  logic        st_tx_hold_empty,
  input  logic        st_tx_idle,
  input  logic        ev_overrun,
  input  logic        ev_parity,
  input  logic        ev_framing,
  input  logic        ev_break,
  output logic [1:0]  word_len,
  output logic        two_stop,
  output logic        parity_en,
  output logic        even_parity,
  output logic        stick_parity,
  output logic        send_break,
  output logic        div_access,
  output logic        dtr,
  output logic        rts,
  output logic        out1,
  output logic        out2,
  output logic        loopback,
  output logic        auto_flow,
  output logic [3:0]  int_en,
  output logic [15:0] divisor
);
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IEN  = 3'd1;
  localparam logic [2:0] OFS_FIFO = 3'd2;
  localparam logic [2:0] OFS_LINE = 3'd3;
  localparam logic [2:0] OFS_MODM = 3'd4;
  localparam logic [2:0] OFS_LSTS = 3'd5;
  localparam logic [2:0] OFS_MSTS = 3'd6;

  logic [7:0]  line_q;
  logic [5:0]  modem_q;
  logic [3:0]  ien_q;
  logic [15:0] div_q;
  logic [3:0]  err_q;
  logic        rdy_q, hold_q, idle_q;

  wire rd_acc = bus_sel & ~bus_wr;
  wire wr_acc = bus_sel & bus_wr;
  wire bank   = line_q[7];
  wire [3:0] ev_now = {ev_break, ev_framing, ev_parity, ev_overrun};
  wire lsts_rd = rd_acc & (bus_addr == OFS_LSTS);

  assign tx_push     = wr_acc & (bus_addr == OFS_DATA) & ~bank;
  assign rx_pop      = rd_acc & (bus_addr == OFS_DATA) & ~bank;
  assign fifo_ctl_wr = wr_acc & (bus_addr == OFS_FIFO);
  assign tx_byte     = bus_wdata;
  assign fifo_ctl    = bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      modem_q <= '0;
      ien_q   <= '0;
      div_q   <= '0;
    end else if (wr_acc) begin
      case (bus_addr)
        OFS_DATA: if (bank) div_q[7:0] <= bus_wdata;
        OFS_IEN:  if (bank) div_q[15:8] <= bus_wdata;
                  else      ien_q <= bus_wdata[3:0];
        OFS_LINE: line_q  <= bus_wdata;
        OFS_MODM: modem_q <= bus_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      rdy_q  <= 1'b0;
      hold_q <= 1'b1;
      idle_q <= 1'b1;
    end else begin
      err_q  <= (lsts_rd ? 4'd0 : err_q) | ev_now;
      rdy_q  <= st_rx_ready;
      hold_q <= st_tx_hold_empty;
      idle_q <= st_tx_idle;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      OFS_DATA: bus_rdata = bank ? div_q[7:0] : rx_byte;
      OFS_IEN:  bus_rdata = bank ? div_q[15:8] : {4'h0, ien_q};
      OFS_FIFO: bus_rdata = int_id;
      OFS_LINE: bus_rdata = line_q;
      OFS_MODM: bus_rdata = {2'b00, modem_q};
      OFS_LSTS: bus_rdata = {1'b0, idle_q, hold_q, err_q, rdy_q};
      OFS_MSTS: bus_rdata = modem_stat;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign word_len     = line_q[1:0];
  assign two_stop     = line_q[2];
  assign parity_en    = line_q[3];
  assign even_parity  = line_q[4];
  assign stick_parity = line_q[5];
  assign send_break   = line_q[6];
  assign div_access   = line_q[7];
  assign dtr          = modem_q[0];
  assign rts          = modem_q[1];
  assign out1         = modem_q[2];
  assign out2         = modem_q[3];
  assign loopback     = modem_q[4];
  assign auto_flow    = modem_q[5];
  assign int_en       = ien_q;
  assign divisor      = div_q;
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic        rx_pop,
  input logic        tx_push,
  input logic        fifo_ctl_wr,
  input logic        div_access,
  input logic [15:0] divisor,
  input logic [3:0]  int_en,
  input logic [3:0]  err_bits,
  input logic [3:0]  ev_bits
);
  wire lsts_rd = bus_sel && !bus_wr && bus_addr == 3'd5;

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push, rx_pop, fifo_ctl_wr}));

  assert_strobe_needs_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push || rx_pop || fifo_ctl_wr) |-> bus_sel);

  assert_no_data_strobe_in_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_access |-> !(tx_push || rx_pop));

  assert_divisor_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && div_access) |=> $stable(divisor));

  assert_ien_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == 3'd1) |=> $stable(int_en));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lsts_rd |=> ((err_bits & $past(err_bits)) == $past(err_bits)));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lsts_rd |=> (err_bits == $past(ev_bits)));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .rx_pop(rx_pop), .tx_push(tx_push), .fifo_ctl_wr(fifo_ctl_wr),
  .div_access(div_access), .divisor(divisor), .int_en(int_en),
  .err_bits(err_q), .ev_bits({ev_break, ev_framing, ev_parity, ev_overrun})
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, rx_byte = 0, tx_byte, fifo_ctl, int_id = 0, modem_stat = 0;
  logic rx_pop, tx_push, fifo_ctl_wr;
  logic st_rx_ready = 0, st_tx_hold_empty = 0, st_tx_idle = 0;
  logic ev_overrun = 0, ev_parity = 0, ev_framing = 0, ev_break = 0;
  logic [1:0] word_len;
  logic two_stop, parity_en, even_parity, stick_parity, send_break, div_access;
  logic dtr, rts, out1, out2, loopback, auto_flow;
  logic [3:0] int_en;
  logic [15:0] divisor;

  always #10 clk = ~clk;

  uart_regbank i_uart_regbank (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_line = 0; logic [5:0] m_mod = 0; logic [3:0] m_ien = 0;
  logic [15:0] m_div = 0; logic [3:0] m_err = 0; logic [2:0] m_live = 3'b110;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return m_line[7] ? m_div[7:0] : rx_byte;
      3'd1: return m_line[7] ? m_div[15:8] : {4'h0, m_ien};
      3'd2: return int_id;
      3'd3: return m_line;
      3'd4: return {2'b00, m_mod};
      3'd5: return {1'b0, m_live[2], m_live[1], m_err, m_live[0]};
      3'd6: return modem_stat;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return m_line[7] ? "R3" : "R2";
      3'd1: return m_line[7] ? "R3" : "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic op(logic w, logic [2:0] a, logic [7:0] d, logic [3:0] ev, logic [2:0] st);
    logic dl;
    dl = m_line[7];
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    {ev_break, ev_framing, ev_parity, ev_overrun} = ev;
    {st_tx_idle, st_tx_hold_empty, st_rx_ready} = st;
    rx_byte = 8'($urandom); int_id = 8'($urandom); modem_stat = 8'($urandom);
    #1;
    if (!w) check(tag_of(a), bus_rdata, exp_read(a));
    check("R2", tx_push, w && a == 0 && !dl);
    check("R2", rx_pop, !w && a == 0 && !dl);
    check("R5", fifo_ctl_wr, w && a == 2);
    if (w && a == 0 && !dl) check("R2", tx_byte, d);
    if (w && a == 2) check("R5", fifo_ctl, d);
    @(posedge clk); @(negedge clk);
    if (w) case (a)
      3'd0: if (dl) m_div[7:0] = d;
      3'd1: if (dl) m_div[15:8] = d; else m_ien = d[3:0];
      3'd3: m_line = d;
      3'd4: m_mod = d[5:0];
      default: ;
    endcase
    m_err = ((!w && a == 5) ? 4'd0 : m_err) | ev;
    m_live = st;
    check("R6", {div_access, send_break, stick_parity, even_parity, parity_en, two_stop, word_len}, m_line);
    check("R7", {auto_flow, loopback, out2, out1, rts, dtr}, m_mod);
    check("R3", divisor, m_div);
    check("R4", int_en, m_ien);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, status read before any capture returns 0x60
    check("R1", {divisor, int_en}, 20'h0);
    op(0, 3'd5, 0, 4'h0, 3'b001);
    check("R1", 16'({auto_flow, loopback, out2, out1, rts, dtr, send_break}), 0);
    // R2 data path, R3 bank switch
    op(1, 3'd0, 8'hA5, 0, 3'b110);
    op(0, 3'd0, 0, 0, 3'b110);
    op(1, 3'd3, 8'h83, 0, 3'b110);
    op(1, 3'd0, 8'h34, 0, 3'b110);
    op(1, 3'd1, 8'h12, 0, 3'b110);
    op(0, 3'd0, 0, 0, 3'b110);
    op(0, 3'd1, 0, 0, 3'b110);
    op(1, 3'd3, 8'h03, 0, 3'b110);
    op(1, 3'd1, 8'hFF, 0, 3'b110);
    op(0, 3'd1, 0, 0, 3'b110);
    // R9: flags latch, clear on read, same-cycle event survives
    op(1, 3'd7, 8'hFF, 4'b0101, 3'b111);
    op(1, 3'd5, 8'hFF, 0, 3'b111);
    op(0, 3'd5, 0, 4'b1000, 3'b000);
    op(0, 3'd5, 0, 0, 3'b000);
    op(0, 3'd5, 0, 0, 3'b000);
    // R10: writes to 5,6,7 ignored
    op(1, 3'd6, 8'hFF, 0, 3'b000);
    op(0, 3'd7, 0, 0, 3'b000);
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a; logic w; logic [7:0] d; logic [3:0] ev;
      a = 3'($urandom); w = 1'($urandom); d = 8'($urandom);
      if (a == 3 && ($urandom % 3) != 0) d[7] = 0;
      ev = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      op(w, a, d, ev, 3'($urandom));
    end
    bus_sel = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule